// File: doc/BRIEF.md
# Input-Capture Timer Channel with Race-Safe Event Flag

This block is one channel of a general-purpose timer used only for input capture. An external input is brought into the clock domain through a synchronizer chain, and its level changes are classified as rising or falling. A two-bit polarity field decides which of those changes count as channel events. On each counted event the channel stores the value of a free-running counter, which the surrounding timer supplies as an input, and sets an event flag. When the interrupt enable is set, that flag drives an interrupt request.

Software reaches the channel through one 32-bit status/control word. It uses a read strobe and a write strobe. Software clears the flag in two steps. First it reads the word while the flag is set, which arms the clear. Then it writes a zero into the flag position. An event that occurs in between disarms the clear, so a pending request is never dropped. The captured value goes out on its own port.

Top module: `tmr_capture_chan`

## Requirements
- R1: After reset the control word reads 0, the captured value is 0, the interrupt is low and the clear is not armed.
- R2: With polarity field (word bits 3:2) equal to 00, no input change sets the flag or loads the captured value.
- R3: Polarity 01 counts rising input changes only, 10 counts falling only, and 11 counts both. An input level first sampled at clock edge k produces its event at edge k+2, and the flag (word bit 7) reads 1 from then on.
- R4: The captured value loads the counter input present at the clock edge that sets the flag for an event, and holds its value at every other edge.
- R5: A read strobe while the flag is 1 arms the clear. A later write whose bit 7 is 0 then clears the flag.
- R6: A write with bit 7 equal to 0 that was not preceded by an arming read leaves the flag set. Any write with bit 7 equal to 1 leaves the flag unchanged and disarms a pending clear.
- R7: An event between the arming read and the clearing write disarms the clear. An event in the same cycle as the clearing write keeps the flag at 1.
- R8: The interrupt output is 1 exactly when the flag and the interrupt enable (word bit 6) are both 1.
- R9: Word bits 31:8 and 1:0 read 0 and ignore writes. Bits 6, 5:4 (mode select, stored only) and 3:2 are read/write. A read returns the current state in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | 1 | Asynchronous external channel input |
| cnt_i | input | CNT_W | Free-running counter value to capture |
| reg_rd_i | input | 1 | Read strobe for the control word |
| reg_wr_i | input | 1 | Write strobe for the control word |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Current control word |
| cap_o | output | CNT_W | Last captured counter value |
| irq_o | output | 1 | Channel interrupt request |

## Verification
The bench aims at the clear sequence's race windows. It places an event between the arming read and the clearing write, and then exactly in the cycle of the clearing write. A design that ignored either window would drop the flag and lose a pending request. It also writes zero with no read before it, and writes a one after a read. A design that cleared the flag on any zero write, or kept the arm across writes, would clear where it must not. Each polarity setting meets both edge directions, so a swapped or ignored polarity decode shows as a wrong flag or a wrong captured value. Two mistakes show as a timing offset against the reference: dropping a synchronizer stage, or sampling the counter one cycle late.

// File: rtl/tcap_pkg.sv
package tcap_pkg;

    localparam int WORD_W   = 32;
    localparam int FLAG_BIT = 7;
    localparam int IE_BIT   = 6;
    localparam int MODE_LO  = 4;
    localparam int POL_LO   = 2;

    typedef enum logic [1:0] {
        POL_OFF  = 2'b00,
        POL_RISE = 2'b01,
        POL_FALL = 2'b10,
        POL_BOTH = 2'b11
    } pol_e;

    typedef struct packed {
        logic       flag;
        logic       ie;
        logic [1:0] mode;
        pol_e       pol;
        logic       arm;
    } ctrl_s;

endpackage

// File: rtl/tcap_edge.sv
module tcap_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic pin_i,
    output logic rise_o,
    output logic fall_o
);
    localparam int LAST = SYNC_STAGES - 1;

    typedef struct packed {
        logic [SYNC_STAGES-1:0] chain;
        logic                   prev;
    } edge_s;

    edge_s st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.chain[0] = pin_i;
        for (int i = 1; i < SYNC_STAGES; i++) begin
            st_d.chain[i] = st_q.chain[i-1];
        end
        st_d.prev     = st_q.chain[LAST];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign rise_o =  st_q.chain[LAST] & ~st_q.prev;
    assign fall_o = ~st_q.chain[LAST] &  st_q.prev;

    // R3
    edge_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({rise_o, fall_o}));

endmodule

// File: rtl/tcap_qual.sv
module tcap_qual
    import tcap_pkg::*;
(
    input  pol_e pol_i,
    input  logic rise_i,
    input  logic fall_i,
    output logic evt_o
);
    always_comb begin
        unique case (pol_i)
            POL_RISE: evt_o = rise_i;
            POL_FALL: evt_o = fall_i;
            POL_BOTH: evt_o = rise_i | fall_i;
            default:  evt_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/tcap_ctrl.sv
module tcap_ctrl
    import tcap_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              rd_i,
    input  logic              wr_i,
    input  logic [WORD_W-1:0] wdata_i,
    input  logic              evt_i,
    output logic [WORD_W-1:0] rdata_o,
    output pol_e              pol_o,
    output logic              irq_o
);
    ctrl_s st_d, st_q;
    logic  clr_req;
    logic  unused_wbits;

    assign unused_wbits = ^{wdata_i[WORD_W-1:FLAG_BIT+1], wdata_i[POL_LO-1:0]};
    assign clr_req      = wr_i & st_q.arm & ~wdata_i[FLAG_BIT];

    always_comb begin
        st_d = st_q;
        if (wr_i) begin
            st_d.ie   = wdata_i[IE_BIT];
            st_d.mode = wdata_i[MODE_LO+1:MODE_LO];
            st_d.pol  = pol_e'(wdata_i[POL_LO+1:POL_LO]);
            st_d.arm  = 1'b0;
            if (clr_req) st_d.flag = 1'b0;
        end else if (rd_i && st_q.flag) begin
            st_d.arm = 1'b1;
        end
        if (evt_i) begin
            st_d.flag = 1'b1;
            st_d.arm  = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    always_comb begin
        rdata_o                        = '0;
        rdata_o[FLAG_BIT]              = st_q.flag;
        rdata_o[IE_BIT]                = st_q.ie;
        rdata_o[MODE_LO+1:MODE_LO]     = st_q.mode;
        rdata_o[POL_LO+1:POL_LO]       = st_q.pol;
    end

    assign pol_o = st_q.pol;
    assign irq_o = st_q.flag & st_q.ie;

    // R5
    no_spur_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(st_q.flag) |-> $past(wr_i && st_q.arm && !wdata_i[FLAG_BIT]));

    // R7
    arm_implies_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.arm |-> st_q.flag);

    // R3
    flag_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(st_q.flag) |-> $past(evt_i));

endmodule

// File: rtl/tmr_capture_chan.sv
module tmr_capture_chan
    import tcap_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              pin_i,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic              reg_rd_i,
    input  logic              reg_wr_i,
    input  logic [31:0]       reg_wdata_i,
    output logic [31:0]       reg_rdata_o,
    output logic [CNT_W-1:0]  cap_o,
    output logic              irq_o
);
    logic rise, fall, evt;
    pol_e pol;
    logic [CNT_W-1:0] cap_d, cap_q;

    tcap_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .pin_i  (pin_i),
        .rise_o (rise),
        .fall_o (fall)
    );

    tcap_qual u_qual (
        .pol_i  (pol),
        .rise_i (rise),
        .fall_i (fall),
        .evt_o  (evt)
    );

    tcap_ctrl u_ctrl (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .rd_i    (reg_rd_i),
        .wr_i    (reg_wr_i),
        .wdata_i (reg_wdata_i),
        .evt_i   (evt),
        .rdata_o (reg_rdata_o),
        .pol_o   (pol),
        .irq_o   (irq_o)
    );

    always_comb begin
        cap_d = cap_q;
        if (evt) cap_d = cnt_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cap_q <= '0;
        else         cap_q <= cap_d;
    end

    assign cap_o = cap_q;

    // R4
    cap_with_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(cap_q) |-> reg_rdata_o[FLAG_BIT]);

endmodule

// File: tb/tmr_capture_chan_bench.sv
module tmr_capture_chan_bench;
    localparam int PERIOD = 10;
    localparam int CW     = 16;

    logic          clk = 0, rst_n = 0, pin = 0, rd = 0, we = 0;
    logic [CW-1:0] cnt = 0;
    logic [31:0]   wd = 0, rdata;
    logic [CW-1:0] cap;
    logic          irq;
    int            vectors = 0, miss = 0;
    bit            done = 0;

    // reference model state
    int  hist[$] = '{0, 0, 0};
    bit  m_flag, m_ie, m_arm;
    int  m_mode, m_pol, m_cap;

    tmr_capture_chan #(.CNT_W(CW), .SYNC_STAGES(2)) u_tmr_capture_chan (
        .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .cnt_i(cnt),
        .reg_rd_i(rd), .reg_wr_i(we), .reg_wdata_i(wd),
        .reg_rdata_o(rdata), .cap_o(cap), .irq_o(irq)
    );

    always #(PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) begin
            hist = '{0, 0, 0};
            m_flag = 0; m_ie = 0; m_arm = 0; m_mode = 0; m_pol = 0; m_cap = 0;
        end else begin
            bit r, f, e, nf, na;
            r  = (hist[1] == 1) && (hist[2] == 0);
            f  = (hist[1] == 0) && (hist[2] == 1);
            e  = (m_pol == 1 && r) || (m_pol == 2 && f) || (m_pol == 3 && (r || f));
            nf = m_flag; na = m_arm;
            if (we) begin
                if (m_arm && !wd[7]) nf = 0;
                na = 0;
                m_ie = wd[6]; m_mode = int'(wd[5:4]); m_pol = int'(wd[3:2]);
            end else if (rd && m_flag) na = 1;
            if (e) begin nf = 1; na = 0; m_cap = int'(cnt); end
            m_flag = nf; m_arm = na;
            hist.push_front(int'(pin));
            void'(hist.pop_back());
        end
    end

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        vectors++;
        if (act !== exp) begin
            miss++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic compare();
        logic [31:0] ew;
        ew = {24'b0, m_flag, m_ie, m_mode[1:0], m_pol[1:0], 2'b00};
        chk({31'b0, rdata[7]}, {31'b0, m_flag}, "R3 R5 R6 R7 flag");
        chk(rdata, ew, "R9 R2 word");
        chk({16'b0, cap}, m_cap, "R4 capture");
        chk({31'b0, irq}, {31'b0, m_flag & m_ie}, "R8 irq");
    endtask

    task automatic tick(input bit r, input bit w, input logic [31:0] d);
        rd = r; we = w; wd = d;
        @(posedge clk);
        @(negedge clk);
        compare();
        rd = 0; we = 0; wd = 32'h0;
        cnt = cnt + 16'd13;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick(0, 0, 0);
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, miss);
            $finish;
        end
    endtask

    initial begin
        #(PERIOD * 200000);
        miss++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(rdata, 32'h0, "R1 word");
        chk({16'b0, cap}, 32'h0, "R1 capture");
        chk({31'b0, irq}, 32'h0, "R1 irq");
        rst_n = 1;
        idle(2);

        // R2 polarity off: toggles ignored
        pin = 1; idle(4); pin = 0; idle(4);
        chk(rdata, 32'h0, "R2 no flag");

        // R9 reserved bits ignored, fields stored; pol=01 ie=1 mode=11
        tick(0, 1, 32'hABCD_00F7);
        chk(rdata, 32'h0000_0074, "R9 layout");

        // R3 rising edge: flag at third edge
        pin = 1; tick(0, 0, 0); tick(0, 0, 0);
        chk({31'b0, rdata[7]}, 0, "R3 not yet");
        tick(0, 0, 0);
        chk({31'b0, rdata[7]}, 1, "R3 flag set");
        chk({31'b0, irq}, 1, "R8 irq on");
        idle(2);
        // falling with rising-only polarity: capture stable
        pin = 0; idle(5);

        // R5 clear sequence
        tick(1, 0, 0); tick(0, 1, 32'h74);
        chk({31'b0, rdata[7]}, 0, "R5 cleared");
        chk({31'b0, irq}, 0, "R8 irq off");

        // R6: zero write without read; one write disarms
        pin = 1; idle(4);
        tick(0, 1, 32'h74);
        chk({31'b0, rdata[7]}, 1, "R6 no read");
        tick(1, 0, 0); tick(0, 1, 32'hF4); tick(0, 1, 32'h74);
        chk({31'b0, rdata[7]}, 1, "R6 disarmed");

        // pol=11, ie=0 (R8 masking), R7 event between read and write
        tick(0, 1, 32'h0C);
        tick(1, 0, 0);
        pin = 0; idle(4);
        tick(0, 1, 32'h0C);
        chk({31'b0, rdata[7]}, 1, "R7 between");
        chk({31'b0, irq}, 0, "R8 masked");

        // R7 event in same cycle as clearing write
        tick(1, 0, 0);
        pin = 1; tick(0, 0, 0); tick(0, 0, 0);
        tick(0, 1, 32'h0C);
        chk({31'b0, rdata[7]}, 1, "R7 same cycle");

        // clear, then pol=10 falling only
        tick(1, 0, 0); tick(0, 1, 32'h48);
        chk({31'b0, rdata[7]}, 0, "R5 cleared again");
        pin = 0; idle(4);
        chk({31'b0, rdata[7]}, 1, "R3 falling");
        tick(1, 0, 0); tick(0, 1, 32'h48);
        pin = 1; idle(5);
        chk({31'b0, rdata[7]}, 0, "R3 rise ignored");

        // both edges, mixed pattern
        tick(0, 1, 32'h6C);
        for (int i = 0; i < 40; i++) begin
            pin = (i % 7 < 3);
            if (i % 11 == 5) tick(1, 0, 0);
            else if (i % 11 == 6) tick(0, 1, 32'h6C);
            else tick(0, 0, 0);
        end
        idle(4);
        summary();
    end
endmodule